// File: doc/BRIEF.md
# Dual Wiper Serial Control Port

This block is the digital front end of a dual digital potentiometer. A host drives three serial lines: a frame enable, a serial clock and a data line. While the enable is high, each rising edge of the serial clock moves one data bit into a 17-bit frame register. A frame holds a stack-select bit and two 8-bit wiper codes. The wiper and stack-select holding registers change only when the enable falls. At that moment they take a copy of the frame register.

The last bit of the frame register is always driven on a cascade output. The data line of the next device in a chain connects to this output. If the cascade output of the last device is fed back to the data line of the first, the host can read the settings by circulating them through the chain. This does not change any setting. The serial lines are asynchronous to the system clock. Each one is brought into the clock domain through a synchronizer of `SYNC_STAGES` flops before any edge is detected.

A controller with three states orders the work:
- `ST_IDLE` waits for the enable. Transition T_START moves to `ST_SHIFT` when the synchronized enable is high.
- `ST_SHIFT` shifts one bit on each detected rising edge of the serial clock. Transition T_END moves to `ST_COMMIT` when the enable drops.
- `ST_COMMIT` copies the frame into the holding registers for one cycle. Transition T_DONE then returns to `ST_IDLE`.

Reset loads every register from the nonvolatile store inputs.

Top module: `pot_serial_front`

## Requirements
- R1: While `rst_n` is low, `wiper0`, `wiper1` and `stack_sel` take the values of `nv_wiper0`, `nv_wiper1` and `nv_stack`. The frame register is loaded with {nv_stack, nv_wiper1, nv_wiper0}, so `cascade_out` equals `nv_stack`.
- R2: While `ser_en` is high, each rising edge of `ser_clk` shifts the frame register one place toward its top bit and loads `ser_din` into bit 0. In a 17-bit frame the stack-select bit comes first, then the wiper-1 code with its MSB first, then the wiper-0 code with its MSB first.
- R3: The outputs `wiper0`, `wiper1` and `stack_sel` change only after `ser_en` falls. At that point they take frame bits [7:0], [15:8] and [16] respectively.
- R4: `cascade_out` always shows frame bit 16. After each shift it shows the next bit of the frame.
- R5: Edges on `ser_clk` while `ser_en` is low are ignored. The frame register, `cascade_out` and the wiper outputs do not change.
- R6: Feed `cascade_out` back to `ser_din` for 17 shifts, then let `ser_en` fall. The wiper and stack-select outputs stay at their previous values.
- R7: When more than 17 bits are shifted, each bit appears on `cascade_out` 17 shifts after it entered. Only the last 17 bits are kept for the commit, as needed for a chain of N devices clocked with 17×N bits.
- R8: `comb_pos` equals {stack_sel, stack_sel ? wiper1 : wiper0}. This gives 512 positions across the two stacked wipers. Code FF hex is the high end of a wiper and 00 hex is the low end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nv_wiper0 | input | WIPER_W | Power-up code for wiper 0 from the nonvolatile store |
| nv_wiper1 | input | WIPER_W | Power-up code for wiper 1 from the nonvolatile store |
| nv_stack | input | 1 | Power-up stack-select value from the nonvolatile store |
| ser_en | input | 1 | Serial frame enable; a falling edge commits the frame |
| ser_clk | input | 1 | Serial clock; a rising edge shifts one bit |
| ser_din | input | 1 | Serial data in |
| cascade_out | output | 1 | Top bit of the frame register, for chaining and readback |
| wiper0 | output | WIPER_W | Committed wiper-0 code |
| wiper1 | output | WIPER_W | Committed wiper-1 code |
| stack_sel | output | 1 | Committed stack select; 1 routes wiper 1 to the combined output |
| comb_pos | output | WIPER_W+1 | Combined stacked position |

## Verification
An error in the frame register shows on `cascade_out` within one serial bit, because that pin exposes the register's top bit after every shift. An error in a shift shows there again 17 shifts later. An error in the controller, such as a commit that is lost, late or extra, or a shift while idle, shows on the wiper outputs a few system clocks after the enable falls. Empty frames and recirculated frames make a corrupted register that would otherwise stay hidden appear at the wiper pins.

// File: rtl/pot_pkg.sv
package pot_pkg;
    parameter int unsigned DEF_WIPER_W = 8;
    parameter int unsigned DEF_SYNC    = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } fstate_t;
endpackage

// File: rtl/pot_in_sync.sv
module pot_in_sync #(
    parameter int unsigned SYNC_STAGES = pot_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    input  logic sck_in,
    input  logic din_in,
    output logic en_s,
    output logic din_s,
    output logic sck_rise
);
    localparam int unsigned LINES = 3;

    logic [LINES-1:0] pipe [SYNC_STAGES];
    logic             sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '0;
            sck_prev <= 1'b0;
        end else begin
            pipe[0] <= {en_in, sck_in, din_in};
            for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
            sck_prev <= pipe[SYNC_STAGES-1][1];
        end
    end

    assign en_s     = pipe[SYNC_STAGES-1][2];
    assign din_s    = pipe[SYNC_STAGES-1][0];
    assign sck_rise = pipe[SYNC_STAGES-1][1] & ~sck_prev;
endmodule

// File: rtl/pot_frame_fsm.sv
module pot_frame_fsm
    import pot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic sck_rise,
    output logic shift_en,
    output logic load_en
);
    fstate_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en_s)  state_d = ST_SHIFT;   // T_START
            ST_SHIFT:  if (!en_s) state_d = ST_COMMIT;  // T_END
            ST_COMMIT: state_d = ST_IDLE;               // T_DONE
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        load_en  = 1'b0;
        unique case (state_q)
            ST_SHIFT:  shift_en = en_s & sck_rise;
            ST_COMMIT: load_en  = 1'b1;
            default:   ;
        endcase
    end

    // R3: a frame end always yields exactly one commit cycle
    p_end_commits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !en_s) |=> (state_q == ST_COMMIT));
    p_commit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_IDLE));
    // R5: no shift outside an open frame
    p_no_idle_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |-> !shift_en);
endmodule

// File: rtl/pot_frame_shreg.sv
module pot_frame_shreg #(
    parameter int unsigned FRAME_W = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] init_val,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] sr_q,
    output logic               ser_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= init_val;
        else if (shift_en) sr_q <= {sr_q[FRAME_W-2:0], din};
    end

    assign ser_out = sr_q[FRAME_W-1];

    p_shift_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sr_q == {$past(sr_q[FRAME_W-2:0]), $past(din)}));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/pot_serial_front.sv
module pot_serial_front
    import pot_pkg::*;
#(
    parameter int unsigned WIPER_W     = DEF_WIPER_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIPER_W-1:0] nv_wiper0,
    input  logic [WIPER_W-1:0] nv_wiper1,
    input  logic               nv_stack,
    input  logic               ser_en,
    input  logic               ser_clk,
    input  logic               ser_din,
    output logic               cascade_out,
    output logic [WIPER_W-1:0] wiper0,
    output logic [WIPER_W-1:0] wiper1,
    output logic               stack_sel,
    output logic [WIPER_W:0]   comb_pos
);
    localparam int unsigned FRAME_W = 2 * WIPER_W + 1;
    localparam int unsigned W1_LO   = WIPER_W;
    localparam int unsigned SEL_BIT = FRAME_W - 1;

    logic               en_s, din_s, sck_rise, shift_en, load_en;
    logic [FRAME_W-1:0] sr_q;

    pot_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .en_in(ser_en), .sck_in(ser_clk), .din_in(ser_din),
        .en_s(en_s), .din_s(din_s), .sck_rise(sck_rise)
    );

    pot_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en_s(en_s), .sck_rise(sck_rise),
        .shift_en(shift_en), .load_en(load_en)
    );

    pot_frame_shreg #(.FRAME_W(FRAME_W)) u_shreg (
        .clk(clk), .rst_n(rst_n),
        .init_val({nv_stack, nv_wiper1, nv_wiper0}),
        .shift_en(shift_en), .din(din_s),
        .sr_q(sr_q), .ser_out(cascade_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper0    <= nv_wiper0;
            wiper1    <= nv_wiper1;
            stack_sel <= nv_stack;
        end else if (load_en) begin
            wiper0    <= sr_q[WIPER_W-1:0];
            wiper1    <= sr_q[W1_LO +: WIPER_W];
            stack_sel <= sr_q[SEL_BIT];
        end
    end

    assign comb_pos = {stack_sel, stack_sel ? wiper1 : wiper0};

    // R3: commit copies the frame, otherwise settings hold
    p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> ({stack_sel, wiper1, wiper0} == $past(sr_q)));
    p_settings_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(wiper0) && $stable(wiper1) && $stable(stack_sel)));
endmodule

// File: tb/pot_serial_front_bench.sv
module pot_serial_front_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int FW = 2 * W + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
    logic [W-1:0] nv_w0 = 8'h5A, nv_w1 = 8'hC3;
    logic nv_st = 1'b0;
    logic cascade_out, stack_sel;
    logic [W-1:0] wiper0, wiper1;
    logic [W:0] comb_pos;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;
    logic [FW-1:0] exp_sr;
    logic [FW-1:0] exp_set;

    always #(CLK_PERIOD/2) clk = ~clk;

    pot_serial_front u_pot_serial_front (
        .clk(clk), .rst_n(rst_n), .nv_wiper0(nv_w0), .nv_wiper1(nv_w1),
        .nv_stack(nv_st), .ser_en(ser_en), .ser_clk(ser_clk), .ser_din(ser_din),
        .cascade_out(cascade_out), .wiper0(wiper0), .wiper1(wiper1),
        .stack_sel(stack_sel), .comb_pos(comb_pos)
    );

    function automatic logic [W:0] pos_of(input logic [FW-1:0] s);
        return {s[FW-1], s[FW-1] ? s[FW-2:W] : s[W-1:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_settings(input string req);
        chk(req, {23'd0, stack_sel, wiper1, wiper0}, {15'd0, exp_set});
        chk({req, "/R8 comb_pos"}, {23'd0, comb_pos}, {23'd0, pos_of(exp_set)});
    endtask

    task automatic clk_bit(input logic b);
        ser_din = b; tick(4);
        ser_clk = 1'b1; tick(4);
        ser_clk = 1'b0; tick(4);
        exp_sr = {exp_sr[FW-2:0], b};
    endtask

    task automatic open_frame;
        ser_en = 1'b1; tick(5);
    endtask

    task automatic close_frame;
        check_settings("R3 before fall");
        ser_en = 1'b0; tick(6);
        exp_set = exp_sr;
        check_settings("R3 after fall");
    endtask

    initial begin : main
        logic [FW-1:0] frame, saved;
        logic [33:0] longf;
        int len;
        void'($urandom(32'd20240611));
        exp_sr = {nv_st, nv_w1, nv_w0};
        exp_set = exp_sr;
        tick(3);
        // R1: reset state comes from the nonvolatile inputs
        check_settings("R1 reset");
        chk("R1 cascade", {31'd0, cascade_out}, {31'd0, nv_st});
        rst_n = 1'b1; tick(3);
        check_settings("R1 after release");

        // R2/R8: directed frame, stack=1, wiper1=FF, wiper0=00
        frame = {1'b1, 8'hFF, 8'h00};
        open_frame;
        for (int i = FW - 1; i >= 0; i--) begin
            clk_bit(frame[i]);
            chk("R4 cascade", {31'd0, cascade_out}, {31'd0, exp_sr[FW-1]});
        end
        chk("R2 frame order", {15'd0, exp_sr}, {15'd0, frame});
        close_frame;

        // R2: stack=0 selects wiper 0, low-end code
        frame = {1'b0, 8'h3C, 8'h00};
        open_frame;
        for (int i = FW - 1; i >= 0; i--) clk_bit(frame[i]);
        close_frame;

        // R5: serial clocks while enable is low are ignored
        for (int i = 0; i < 6; i++) begin
            ser_din = ~cascade_out; tick(4);
            ser_clk = 1'b1; tick(4);
            ser_clk = 1'b0; tick(4);
            chk("R5 cascade idle", {31'd0, cascade_out}, {31'd0, exp_sr[FW-1]});
        end
        check_settings("R5 settings idle");
        open_frame;
        close_frame;

        // R6: recirculate cascade output into data input
        saved = exp_set;
        open_frame;
        for (int i = 0; i < FW; i++) clk_bit(cascade_out);
        close_frame;
        chk("R6 recirculate", {15'd0, exp_set}, {15'd0, saved});

        // R7: 34-bit frame, bits reappear 17 shifts later
        longf = {$urandom(), $urandom()};
        open_frame;
        for (int j = 0; j < 34; j++) begin
            if (j >= FW)
                chk("R7 delayed bit", {31'd0, cascade_out}, {31'd0, longf[33 - (j - FW)]});
            clk_bit(longf[33 - j]);
        end
        chk("R7 last 17 kept", {15'd0, exp_sr}, {15'd0, longf[FW-1:0]});
        close_frame;

        // random frames of random length
        for (int f = 0; f < 24; f++) begin
            len = (f % 3 == 0) ? FW : int'($urandom_range(1, 40));
            open_frame;
            for (int b = 0; b < len; b++) begin
                clk_bit(1'($urandom_range(0, 1)));
                chk("R4 cascade rand", {31'd0, cascade_out}, {31'd0, exp_sr[FW-1]});
            end
            close_frame;
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule